// File: doc/BRIEF.md
# Network Wakeup Power-State Controller

This block sits on the receive side of a network interface and decides, frame by frame, whether a received frame is handed on to the host, thrown away, or treated as a request to wake the host. It tracks a five-state power condition that follows whether the host bus has power, a wake-enable control bit, and a stored configuration bit that chooses the state taken after reset. A built-in detector looks for a wake pattern addressed to a programmed 48-bit station address. Two receive ports are provided; a select input chooses which one feeds both the frame decision and the detector.

Frames arrive as a byte stream with start, valid, end and good-CRC flags. One cycle after the last byte of a frame, the block pulses a done flag together with an accept flag. A wake output is raised when the wake pattern arrives while the host sleeps, and it stays high until the host clears it. State changes caused by bus power never take effect inside a frame; they wait until the frame has ended.

Top module: `wk_ctrl`

## Requirements
- R1: After `rst_n` is released the state output reads 3 (reset state) with wake and done low; the reset state lasts exactly six rising edges after release (two of reset synchronisation plus four of reset hold), and the state changes at the sixth.
- R2: On leaving the reset state the block goes to 2 (standby) when `cfg_lowpwr`=1 and `bus_pwr`=1, to 1 (suspend) when `cfg_lowpwr`=1 and `bus_pwr`=0, to 0 (normal) when `cfg_lowpwr`=0 and `bus_pwr`=1, and to 4 (dropping) when both are 0.
- R3: In state 0 with wake enable at 0, a frame ending with `crc_ok`=1 gives `frm_done`=1 and `frm_accept`=1 one cycle after its last byte; a frame with bad CRC gives `frm_accept`=0; a wake-pattern frame is accepted as ordinary data and raises no wake.
- R4: The wake-enable bit, written through `wen_we`/`wen_d`, is 0 after reset; while it is 1, no frame is accepted in any state.
- R5: In states 1 and 2 every frame is discarded; a wake-pattern frame ending with good CRC while wake enable is 1 sets `wake_o` and moves the state to 0 in the cycle after its last byte.
- R6: A wake pattern is at least six bytes of 0xFF followed directly by sixteen back-to-back copies of the station address, the first address byte sent being `sta_addr[47:40]`; junk or shorter 0xFF runs before it are allowed, while fifteen copies, one wrong byte, only five 0xFF bytes, or a bad CRC give no wake.
- R7: `wake_o` stays high until a `wake_clr` pulse, and is driven low whenever wake enable is 0.
- R8: While `wake_o` is high the state stays 0 whatever `bus_pwr` does; after the clear, normal bus-power rules apply again.
- R9: At a frame boundary: state 0 with `bus_pwr`=0 goes to 1 if wake enable is 1, else to 4; state 4 goes to 0 when `bus_pwr`=1, or to 1 when wake enable is 1; state 1 goes to 2 when `bus_pwr`=1; state 2 goes to 1 when `bus_pwr`=0.
- R10: A state change caused by bus power or wake enable never happens between a frame's first and last byte; it takes effect on the cycle after the last byte.
- R11: In state 4 every frame is discarded.
- R12: A `reset_req` pulse moves the state to 3 on the next edge, even in the middle of a frame, clears wake enable and `wake_o`; frames ending in state 3 are discarded.
- R13: `rx_sel`=0 selects port 0 and `rx_sel`=1 selects port 1; traffic on the unselected port produces no done pulse and no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sta_addr | input | 48 | Station address the wake pattern must repeat |
| cfg_lowpwr | input | 1 | Stored setting: come out of reset in a wake-waiting state |
| bus_pwr | input | 1 | Host bus has power |
| wen_we | input | 1 | Write strobe for the wake-enable bit |
| wen_d | input | 1 | Value written to the wake-enable bit |
| reset_req | input | 1 | Synchronous request to enter the reset state |
| wake_clr | input | 1 | Write-one-to-clear strobe for the wake output |
| rx_sel | input | 1 | Receive port select |
| p0_sof | input | 1 | Port 0 first byte of frame |
| p0_vld | input | 1 | Port 0 byte valid |
| p0_eof | input | 1 | Port 0 last byte of frame |
| p0_crc_ok | input | 1 | Port 0 CRC good, sampled with the last byte |
| p0_data | input | 8 | Port 0 byte |
| p1_sof | input | 1 | Port 1 first byte of frame |
| p1_vld | input | 1 | Port 1 byte valid |
| p1_eof | input | 1 | Port 1 last byte of frame |
| p1_crc_ok | input | 1 | Port 1 CRC good, sampled with the last byte |
| p1_data | input | 8 | Port 1 byte |
| frm_done | output | 1 | One-cycle pulse after a frame's last byte |
| frm_accept | output | 1 | Frame passed to host, valid with frm_done |
| wake_o | output | 1 | Wake request to host |
| state_o | output | 3 | Current state: 0 normal, 1 suspend, 2 standby, 3 reset, 4 dropping |

## Verification
The decision logic is swept across all four running states, both wake-enable values and three frame kinds (good ordinary frame, bad-CRC frame, good wake pattern), which separates the accept path from the wake path and shows which state gates which. The detector is tried with exact and near-miss patterns: missing copy, single corrupted byte, short 0xFF run, bad CRC, and patterns preceded by junk or extra 0xFF bytes, which tell a correct sliding match from a fixed-offset one. Bus-power changes are made in the middle of frames to show that transitions wait for the frame boundary, and wake is driven on the unselected port to prove the port mux isolates it.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [2:0] {
    ST_NORM = 3'd0,
    ST_SUSP = 3'd1,
    ST_STBY = 3'd2,
    ST_RST  = 3'd3,
    ST_DROP = 3'd4
  } wk_state_e;

  typedef struct packed {
    logic       sof;
    logic       vld;
    logic       eof;
    logic       crc_ok;
    logic [7:0] data;
  } wk_beat_t;

endpackage

// File: rtl/wk_rst_sync.sv
module wk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/wk_port_sel.sv
module wk_port_sel
  import wk_pkg::*;
#(
  parameter int N_PORTS = 2,
  localparam int SELW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  wk_beat_t         beats [N_PORTS],
  input  logic [SELW-1:0]  sel,
  output wk_beat_t         beat_o
);

  wk_beat_t masked [N_PORTS];

  // Each port is gated by its own select match, then all are OR-ed.
  for (genvar p = 0; p < N_PORTS; p++) begin : g_gate
    assign masked[p] = (sel == SELW'(p)) ? beats[p] : '0;
  end

  always_comb begin
    beat_o = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      beat_o = beat_o | masked[p];
    end
  end

endmodule

// File: rtl/wk_magic_det.sv
module wk_magic_det
  import wk_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPS       = 16,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int SW = $clog2(SYNC_LEN + 1),
  localparam int BW = $clog2(ADDR_BYTES),
  localparam int RW = $clog2(REPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wk_beat_t      beat,
  input  logic [AW-1:0] addr,
  output logic          hit_o
);

  logic [7:0] addr_b [ADDR_BYTES];

  // First byte on the wire is the most significant address byte.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_unpack
    assign addr_b[k] = addr[AW-1-8*k -: 8];
  end

  logic [SW-1:0] sync_q, sync_b, sync_n;
  logic [BW-1:0] bidx_q, bidx_b, bidx_n;
  logic [RW-1:0] rep_q, rep_b, rep_n;
  logic          hit_q, hit_b, hit_n;
  logic          done_now;
  logic          is_ff;

  // A start-of-frame byte is scored from an empty match history.
  assign sync_b = beat.sof ? '0   : sync_q;
  assign bidx_b = beat.sof ? '0   : bidx_q;
  assign rep_b  = beat.sof ? '0   : rep_q;
  assign hit_b  = beat.sof ? 1'b0 : hit_q;
  assign is_ff  = (beat.data == 8'hFF);

  always_comb begin
    sync_n   = sync_b;
    bidx_n   = bidx_b;
    rep_n    = rep_b;
    hit_n    = hit_b;
    done_now = 1'b0;
    if (!hit_b) begin
      if (sync_b != SW'(SYNC_LEN)) begin
        sync_n = is_ff ? sync_b + SW'(1) : '0;
      end else if (beat.data == addr_b[bidx_b]) begin
        if (bidx_b == BW'(ADDR_BYTES - 1)) begin
          bidx_n = '0;
          if (rep_b == RW'(REPS - 1)) begin
            rep_n    = '0;
            hit_n    = 1'b1;
            done_now = 1'b1;
          end else begin
            rep_n = rep_b + RW'(1);
          end
        end else begin
          bidx_n = bidx_b + BW'(1);
        end
      end else if (is_ff && bidx_b == '0 && rep_b == '0) begin
        sync_n = sync_b;
      end else begin
        sync_n = is_ff ? SW'(1) : '0;
        bidx_n = '0;
        rep_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      bidx_q <= '0;
      rep_q  <= '0;
      hit_q  <= 1'b0;
    end else if (beat.vld) begin
      sync_q <= sync_n;
      bidx_q <= bidx_n;
      rep_q  <= rep_n;
      hit_q  <= hit_n;
    end
  end

  assign hit_o = beat.vld & (hit_b | done_now);

  // R6: a completed match is only reachable after a full 0xFF run.
  a_r6_hit_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (beat.vld && !hit_b && done_now) |-> (sync_b == SW'(SYNC_LEN)));

endmodule

// File: rtl/wk_state_fsm.sv
module wk_state_fsm
  import wk_pkg::*;
#(
  parameter int RST_LEN = 4,
  localparam int CW = $clog2(RST_LEN)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reset_req,
  input  logic      cfg_lowpwr,
  input  logic      bus_pwr,
  input  logic      wen,
  input  wk_beat_t  beat,
  input  logic      magic_ok,
  input  logic      wake_clr,
  output wk_state_e state_o,
  output logic      wake_o
);

  wk_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          open_q, open_n;
  logic          wake_q, wake_n;
  logic          boundary;
  logic          wake_set;
  logic          low_pwr;

  assign open_n   = ((beat.vld & beat.sof) | open_q) & ~(beat.vld & beat.eof);
  assign boundary = ~open_n;
  assign low_pwr  = (state_q == ST_SUSP) || (state_q == ST_STBY);
  assign wake_set = magic_ok & wen & low_pwr;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RST: begin
        if (cnt_q == CW'(RST_LEN - 1) && boundary) begin
          if (cfg_lowpwr) state_n = bus_pwr ? ST_STBY : ST_SUSP;
          else            state_n = bus_pwr ? ST_NORM : ST_DROP;
        end
      end
      ST_NORM: begin
        if (boundary && !bus_pwr && !wake_q) state_n = wen ? ST_SUSP : ST_DROP;
      end
      ST_DROP: begin
        if (boundary) begin
          if (bus_pwr)  state_n = ST_NORM;
          else if (wen) state_n = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (wake_set)                 state_n = ST_NORM;
        else if (boundary && bus_pwr) state_n = ST_STBY;
      end
      ST_STBY: begin
        if (wake_set)                  state_n = ST_NORM;
        else if (boundary && !bus_pwr) state_n = ST_SUSP;
      end
      default: state_n = ST_RST;
    endcase
    if (reset_req) state_n = ST_RST;
  end

  always_comb begin
    cnt_n = '0;
    if (state_q == ST_RST && !reset_req) begin
      cnt_n = (cnt_q == CW'(RST_LEN - 1)) ? cnt_q : cnt_q + CW'(1);
    end
  end

  always_comb begin
    wake_n = wake_q;
    if (wake_clr) wake_n = 1'b0;
    if (wake_set) wake_n = 1'b1;
    if (!wen || reset_req) wake_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST;
      cnt_q   <= '0;
      open_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      open_q  <= open_n;
      wake_q  <= wake_n;
    end
  end

  assign state_o = state_q;
  assign wake_o  = wake_q;

  a_r1_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST && cnt_q != CW'(RST_LEN - 1)) |=> (state_q == ST_RST));

  a_r5_wake_from_low_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> ($past(state_q) == ST_SUSP || $past(state_q) == ST_STBY));

  a_r7_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> !wake_q);

  a_r8_normal_while_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !reset_req) |=> (state_q == ST_NORM));

  a_r10_no_mid_frame_change: assert property (@(posedge clk) disable iff (!rst_n)
    (open_n && !reset_req) |=> $stable(state_q));

  a_r12_request_enters_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (state_q == ST_RST && !wake_q));

endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
  import wk_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPS       = 16,
  parameter int RST_LEN    = 4,
  localparam int AW        = 8 * ADDR_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sta_addr,
  input  logic          cfg_lowpwr,
  input  logic          bus_pwr,
  input  logic          wen_we,
  input  logic          wen_d,
  input  logic          reset_req,
  input  logic          wake_clr,
  input  logic          rx_sel,
  input  logic          p0_sof,
  input  logic          p0_vld,
  input  logic          p0_eof,
  input  logic          p0_crc_ok,
  input  logic [7:0]    p0_data,
  input  logic          p1_sof,
  input  logic          p1_vld,
  input  logic          p1_eof,
  input  logic          p1_crc_ok,
  input  logic [7:0]    p1_data,
  output logic          frm_done,
  output logic          frm_accept,
  output logic          wake_o,
  output logic [2:0]    state_o
);

  localparam int N_PORTS = 2;

  logic      rst_i;
  wk_beat_t  beats [N_PORTS];
  wk_beat_t  beat;
  logic      hit;
  logic      magic_ok;
  logic      frame_end;
  logic      wen_q;
  logic      done_q, acc_q;
  wk_state_e state;

  wk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  assign beats[0] = '{sof: p0_sof, vld: p0_vld, eof: p0_eof, crc_ok: p0_crc_ok, data: p0_data};
  assign beats[1] = '{sof: p1_sof, vld: p1_vld, eof: p1_eof, crc_ok: p1_crc_ok, data: p1_data};

  wk_port_sel #(.N_PORTS(N_PORTS)) u_sel (
    .beats  (beats),
    .sel    (rx_sel),
    .beat_o (beat)
  );

  wk_magic_det #(
    .ADDR_BYTES (ADDR_BYTES),
    .SYNC_LEN   (SYNC_LEN),
    .REPS       (REPS)
  ) u_det (
    .clk   (clk),
    .rst_n (rst_i),
    .beat  (beat),
    .addr  (sta_addr),
    .hit_o (hit)
  );

  assign frame_end = beat.vld & beat.eof;
  assign magic_ok  = frame_end & beat.crc_ok & hit;

  wk_state_fsm #(.RST_LEN(RST_LEN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i),
    .reset_req  (reset_req),
    .cfg_lowpwr (cfg_lowpwr),
    .bus_pwr    (bus_pwr),
    .wen        (wen_q),
    .beat       (beat),
    .magic_ok   (magic_ok),
    .wake_clr   (wake_clr),
    .state_o    (state),
    .wake_o     (wake_o)
  );

  // Wake-enable control bit: cleared by reset and by a reset request.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wen_q <= 1'b0;
    end else if (reset_req) begin
      wen_q <= 1'b0;
    end else if (wen_we) begin
      wen_q <= wen_d;
    end
  end

  // Per-frame decision, reported the cycle after the last byte.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      done_q <= frame_end;
      acc_q  <= frame_end & beat.crc_ok & ~wen_q & (state == ST_NORM);
    end
  end

  assign frm_done   = done_q;
  assign frm_accept = acc_q;
  assign state_o    = state;

  a_r3_accept_with_done: assert property (@(posedge clk) disable iff (!rst_i)
    frm_accept |-> frm_done);

  a_r4_enable_blocks_accept: assert property (@(posedge clk) disable iff (!rst_i)
    frm_accept |-> !$past(wen_q));

  a_r11_accept_only_normal: assert property (@(posedge clk) disable iff (!rst_i)
    frm_accept |-> ($past(state) == ST_NORM));

endmodule

// File: tb/tb_wk_ctrl.sv
`timescale 1ns/1ps
module tb_wk_ctrl;

  localparam logic [47:0] ADDR = 48'h02_1A_3C_5E_70_91;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_lowpwr, bus_pwr, wen_we, wen_d, reset_req, wake_clr, rx_sel;
  logic        p0_sof, p0_vld, p0_eof, p0_crc_ok;
  logic [7:0]  p0_data;
  logic        p1_sof, p1_vld, p1_eof, p1_crc_ok;
  logic [7:0]  p1_data;
  logic        frm_done, frm_accept, wake_o;
  logic [2:0]  state_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] fb [0:199];
  int         flen;

  always #2 clk = ~clk;

  wk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sta_addr(ADDR), .cfg_lowpwr(cfg_lowpwr),
    .bus_pwr(bus_pwr), .wen_we(wen_we), .wen_d(wen_d), .reset_req(reset_req),
    .wake_clr(wake_clr), .rx_sel(rx_sel),
    .p0_sof(p0_sof), .p0_vld(p0_vld), .p0_eof(p0_eof), .p0_crc_ok(p0_crc_ok), .p0_data(p0_data),
    .p1_sof(p1_sof), .p1_vld(p1_vld), .p1_eof(p1_eof), .p1_crc_ok(p1_crc_ok), .p1_data(p1_data),
    .frm_done(frm_done), .frm_accept(frm_accept), .wake_o(wake_o), .state_o(state_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_ports();
    {p0_sof, p0_vld, p0_eof, p0_crc_ok} = '0; p0_data = '0;
    {p1_sof, p1_vld, p1_eof, p1_crc_ok} = '0; p1_data = '0;
  endtask

  task automatic put_byte(input int port, input logic [7:0] b,
                          input bit sof, input bit eof, input bit crc);
    idle_ports();
    if (port == 0) begin
      p0_vld = 1; p0_sof = sof; p0_eof = eof; p0_crc_ok = crc & eof; p0_data = b;
    end else begin
      p1_vld = 1; p1_sof = sof; p1_eof = eof; p1_crc_ok = crc & eof; p1_data = b;
    end
    tick();
    idle_ports();
  endtask

  task automatic send(input int port, input bit crc);
    for (int i = 0; i < flen; i++) put_byte(port, fb[i], i == 0, i == flen - 1, crc);
  endtask

  task automatic build_plain(input int n);
    flen = n;
    for (int i = 0; i < n; i++) fb[i] = 8'(i * 5 + 1);
  endtask

  // junk bytes, nff bytes of 0xFF, reps address copies; bad >= 0 flips one byte
  task automatic build_magic(input int junk, input int nff, input int reps, input int bad);
    flen = 0;
    for (int i = 0; i < junk; i++) begin fb[flen] = 8'h40 + 8'(i); flen++; end
    for (int i = 0; i < nff; i++)  begin fb[flen] = 8'hFF; flen++; end
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < 6; k++) begin fb[flen] = ADDR[47-8*k -: 8]; flen++; end
    if (bad >= 0) fb[bad] = fb[bad] ^ 8'h08;
  endtask

  task automatic do_reset(input bit cfg, input bit bus, input bit chk);
    rst_n = 0; cfg_lowpwr = cfg; bus_pwr = bus;
    tick(); tick();
    if (chk) begin
      check("R1 state in reset", state_o, 3);
      check("R1 wake in reset", wake_o, 0);
      check("R1 done in reset", frm_done, 0);
    end
    rst_n = 1;
    for (int i = 0; i < 5; i++) tick();
    if (chk) check("R1 still reset at edge 5", state_o, 3);
    tick();
  endtask

  task automatic write_wen(input bit v);
    wen_we = 1; wen_d = v; tick(); wen_we = 0;
  endtask

  function automatic int exit_state(input bit cfg, input bit bus);
    if (cfg) return bus ? 2 : 1;
    return bus ? 0 : 4;
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_lowpwr = 0; bus_pwr = 0; wen_we = 0; wen_d = 0;
    reset_req = 0; wake_clr = 0; rx_sel = 0;
    idle_ports();

    // R1 / R2: every stored setting and bus-power combination
    for (int c = 0; c < 4; c++) begin
      do_reset(c[1], c[0], 1'b1);
      check("R2 exit state", state_o, exit_state(c[1], c[0]));
    end

    // R3 R4 R5 R11: state x enable x frame kind sweep
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        for (int kind = 0; kind < 3; kind++) begin
          bit cfg, bus;
          int st, st_eff, acc, wk, st_after;
          case (s)
            0: begin cfg = 0; bus = 1; st = 0; end
            1: begin cfg = 1; bus = 0; st = 1; end
            2: begin cfg = 1; bus = 1; st = 2; end
            default: begin cfg = 0; bus = 0; st = 4; end
          endcase
          do_reset(cfg, bus, 1'b0);
          write_wen(w[0]);
          tick();
          st_eff = (st == 4 && w == 1) ? 1 : st;
          check("R9 state before frame", state_o, st_eff);
          if (kind == 2) build_magic(0, 6, 16, -1); else build_plain(20);
          send(0, kind != 1);
          acc = (st_eff == 0 && w == 0 && kind != 1) ? 1 : 0;
          wk  = ((st_eff == 1 || st_eff == 2) && w == 1 && kind == 2) ? 1 : 0;
          st_after = wk ? 0 : st_eff;
          check("R3 done pulse", frm_done, 1);
          if (st_eff == 4) check("R11 drop discards", frm_accept, acc);
          else if (w == 1) check("R4 enable discards", frm_accept, acc);
          else check("R3 accept decision", frm_accept, acc);
          check("R5 wake decision", wake_o, wk);
          check("R5 state after frame", state_o, st_after);
          tick();
          check("R3 done is a pulse", frm_done, 0);
          if (wk) begin
            check("R7 wake held", wake_o, 1);
            wake_clr = 1; tick(); wake_clr = 0;
            check("R7 wake cleared", wake_o, 0);
          end
        end
      end
    end

    // R6: near misses and sliding matches in suspend
    do_reset(1, 0, 1'b0); write_wen(1); tick();
    build_magic(0, 6, 15, -1); send(0, 1); check("R6 fifteen copies", wake_o, 0);
    build_magic(0, 5, 16, -1); send(0, 1); check("R6 five 0xFF", wake_o, 0);
    build_magic(0, 6, 16, 40); send(0, 1); check("R6 wrong byte", wake_o, 0);
    build_magic(0, 6, 16, -1); send(0, 0); check("R6 bad CRC", wake_o, 0);
    check("R6 still suspend", state_o, 1);
    build_magic(5, 9, 16, -1); send(0, 1); check("R6 junk and long run", wake_o, 1);
    wake_clr = 1; tick(); wake_clr = 0; tick();
    check("R8 back to suspend after clear", state_o, 1);
    build_magic(0, 3, 0, -1);
    fb[3] = 8'h11; flen = 4;
    for (int i = 0; i < 6; i++) begin fb[flen] = 8'hFF; flen++; end
    for (int r = 0; r < 16; r++)
      for (int k = 0; k < 6; k++) begin fb[flen] = ADDR[47-8*k -: 8]; flen++; end
    send(0, 1); check("R6 broken run then pattern", wake_o, 1);

    // R8: state stays normal while wake pending, bus unpowered
    tick(); tick();
    check("R8 normal while wake", state_o, 0);
    wake_clr = 1; tick(); wake_clr = 0;
    check("R8 still normal at clear edge", state_o, 0);
    tick();
    check("R9 normal to suspend with enable", state_o, 1);

    // R7: wake dropped when enable is written to 0
    build_magic(0, 6, 16, -1); send(0, 1);
    check("R7 wake set", wake_o, 1);
    write_wen(0); tick();
    check("R7 enable off clears wake", wake_o, 0);

    // R13: port selection
    do_reset(1, 1, 1'b0); write_wen(1); rx_sel = 1; tick();
    build_magic(0, 6, 16, -1); send(0, 1);
    check("R13 unselected port no done", frm_done, 0);
    check("R13 unselected port no wake", wake_o, 0);
    send(1, 1);
    check("R13 selected port wake", wake_o, 1);
    rx_sel = 0;

    // R9 / R10: bus changes inside frames
    do_reset(0, 1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      if (i == 3) bus_pwr = 0;
      put_byte(0, 8'(i), i == 0, i == 9, 1);
      if (i < 9) check("R10 normal held mid frame", state_o, 0);
    end
    check("R9 normal to drop at end", state_o, 4);
    for (int i = 0; i < 10; i++) begin
      if (i == 2) bus_pwr = 1;
      put_byte(0, 8'(i), i == 0, i == 9, 1);
      if (i < 9) check("R10 drop held mid frame", state_o, 4);
    end
    check("R9 drop to normal at end", state_o, 0);
    write_wen(1); bus_pwr = 0; tick();
    check("R9 normal to suspend", state_o, 1);
    bus_pwr = 1; tick();
    check("R9 suspend to standby", state_o, 2);
    bus_pwr = 0; tick();
    check("R9 standby to suspend", state_o, 1);

    // R12: reset request mid frame clears enable
    do_reset(0, 1, 1'b0); write_wen(1);
    for (int i = 0; i < 8; i++) begin
      reset_req = (i == 3);
      put_byte(0, 8'(i), i == 0, i == 7, 1);
      reset_req = 0;
      if (i == 3) check("R12 reset entered", state_o, 3);
    end
    check("R12 frame in reset discarded", frm_accept, 0);
    for (int i = 0; i < 20 && state_o == 3; i++) tick();
    check("R12 leaves to normal", state_o, 0);
    build_plain(12); send(0, 1);
    check("R12 enable cleared so accepted", frm_accept, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule